// File: doc/BRIEF.md
# General-Purpose Parallel Port Controller

This block controls an eight-pin parallel port. It holds three registers: an output data latch, a per-pin direction mask and a per-pin pull enable mask. A small synchronous register bus reaches all three. The bus has a two-bit offset, a write strobe, write data and combinational read data. For every pin the block drives an output-enable, an output level and two pull controls, one for pull-up and one for pull-down, to the pad cell. The incoming pad levels pass through a two-stage synchronizer before they reach the read path.

Reads of the data offset depend on direction. On an output pin the read returns the stored latch bit. On an input pin it returns the synchronized pad level. Two pins are special. Pin 4 is wired as a permanent output. Pin 5 is an open-drain line that can only pull low, and it keeps its pull device while it is an output. The pull polarity for each pin comes from two inputs that the interrupt logic supplies: a pin-interrupt enable and a rising-edge select.

The block has no sequencing state, so its only named states are the register select values: DATA (0), DIR (1), PULL (2) and NONE (3). Decoding the offset moves the bus into one of these states on every access. No other transitions exist.

Top module: `gpio_port`

## Requirements
- R1: After reset the data, direction and pull-enable registers all read 0x00. pad_oe is 0x10, with only pin 4 driving. pad_pu, pad_pd and pad_out are all zero.
- R2: A write with bus_we high stores bus_wdata at the next clock edge. Offset 0 selects the data latch, offset 1 the direction mask and offset 2 the pull-enable mask, and each of these reads back at its own offset. Offset 3 reads 0x00, and writes to it change no register.
- R3: A pin whose direction bit is 0 is an input. On such a pin, excluding pin 4, a read at offset 0 returns the pad level captured two clock edges earlier through the two-stage synchronizer. A new pad level is not visible after only one edge.
- R4: A pin whose direction bit is 1 is an output, excluding pins 4 and 5. Such a pin has pad_oe set and drives its latch bit on pad_out, and a read at offset 0 returns its latch bit. With a direction bit of 0, pad_oe is clear.
- R5: On an input pin, a pull-enable bit of 1 turns on exactly one pull device and a bit of 0 turns both off.
- R6: On pins other than 5, a direction bit of 1 forces both pull controls off, whatever the pull-enable bit holds.
- R7: An active pull is a pull-down when both irq_en and edge_rise are 1 for that pin, and a pull-up otherwise. pad_pu and pad_pd are never both set on a pin.
- R8: Pin 4 always has pad_oe set and drives its latch bit. Its pulls stay off, and a read at offset 0 returns its latch bit. Its direction and pull-enable bits have no effect on the pad but still read back as written.
- R9: Pin 5 never drives high: pad_out[5] is 0. pad_oe[5] is 1 only when its direction bit is 1 and its latch bit is 0. Its pull follows its pull-enable bit whatever its direction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 2 | Register offset |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| pin_in | input | 8 | Pad input levels (asynchronous) |
| irq_en | input | 8 | Per-pin pin-interrupt enable |
| edge_rise | input | 8 | Per-pin rising-edge select |
| pad_oe | output | 8 | Output driver enable |
| pad_out | output | 8 | Output level |
| pad_pu | output | 8 | Pull-up enable |
| pad_pd | output | 8 | Pull-down enable |

## Verification
Some rules must hold in every cycle, and the assertions check those: pull-up and pull-down exclusion, pin 4's permanent enable, open-drain pin 5 never driving high, pulls staying off on driven standard pins, offset-3 writes leaving all registers unchanged, and input-pin reads matching the pad level from two edges back. Other behaviour only the bench scenarios can show. That covers the exact reset values, readback of every register, the missing one-edge path through the synchronizer, and the full steering of the pad controls. The bench checks these against a model computed from the requirements, under random register writes, pad levels and interrupt selects.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

    // Register select decoded from the bus offset
    typedef enum logic [1:0] {
        SEL_DATA = 2'd0,
        SEL_DIR  = 2'd1,
        SEL_PULL = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;

    localparam int unsigned SEL_W = 2;

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int unsigned W      = 8,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    logic [STAGES-1:0][W-1:0] stage_q;

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage_q[s] <= '0;
                    else        stage_q[s] <= d_i;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage_q[s] <= '0;
                    else        stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_regfile.sv
module gpio_regfile
    import gpio_pkg::*;
#(
    parameter int unsigned W            = 8,
    parameter int unsigned OUT_ONLY_BIT = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] addr_i,
    input  logic             we_i,
    input  logic [W-1:0]     wdata_i,
    input  logic [W-1:0]     pin_sync_i,
    output logic [W-1:0]     dat_o,
    output logic [W-1:0]     dir_o,
    output logic [W-1:0]     pe_o,
    output logic [W-1:0]     rdata_o
);

    localparam logic [W-1:0] ONLY_MASK =
        (OUT_ONLY_BIT < W) ? (W'(1) << OUT_ONLY_BIT) : '0;

    reg_sel_e     sel;
    logic [W-1:0] dat_q, dir_q, pe_q;
    logic [W-1:0] latch_view;
    logic [W-1:0] data_view;

    assign sel = reg_sel_e'(addr_i);

    // Register state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dat_q <= '0;
            dir_q <= '0;
            pe_q  <= '0;
        end else if (we_i) begin
            unique case (sel)
                SEL_DATA: dat_q <= wdata_i;
                SEL_DIR:  dir_q <= wdata_i;
                SEL_PULL: pe_q  <= wdata_i;
                SEL_NONE: ;
            endcase
        end
    end

    // Direction steering of data reads
    assign latch_view = dir_q | ONLY_MASK;
    assign data_view  = (latch_view & dat_q) | (~latch_view & pin_sync_i);

    always_comb begin
        unique case (sel)
            SEL_DATA: rdata_o = data_view;
            SEL_DIR:  rdata_o = dir_q;
            SEL_PULL: rdata_o = pe_q;
            SEL_NONE: rdata_o = '0;
        endcase
    end

    assign dat_o = dat_q;
    assign dir_o = dir_q;
    assign pe_o  = pe_q;

endmodule

// File: rtl/gpio_pad_ctrl.sv
module gpio_pad_ctrl #(
    parameter int unsigned W              = 8,
    parameter int unsigned OUT_ONLY_BIT   = 4,
    parameter int unsigned OPEN_DRAIN_BIT = 5
) (
    input  logic [W-1:0] dat_i,
    input  logic [W-1:0] dir_i,
    input  logic [W-1:0] pe_i,
    input  logic [W-1:0] irq_en_i,
    input  logic [W-1:0] rise_i,
    output logic [W-1:0] oe_o,
    output logic [W-1:0] out_o,
    output logic [W-1:0] pu_o,
    output logic [W-1:0] pd_o
);

    genvar i;
    generate
        for (i = 0; i < W; i++) begin : g_pin
            logic pull_on;
            logic want_down;

            assign want_down = irq_en_i[i] & rise_i[i];

            if (i == OUT_ONLY_BIT) begin : g_out_only
                logic unused_cfg;
                assign unused_cfg = ^{dir_i[i], pe_i[i], want_down};
                assign oe_o[i]    = 1'b1;
                assign out_o[i]   = dat_i[i];
                assign pull_on    = 1'b0;
            end else if (i == OPEN_DRAIN_BIT) begin : g_open_drain
                assign oe_o[i]  = dir_i[i] & ~dat_i[i];
                assign out_o[i] = 1'b0;
                assign pull_on  = pe_i[i];
            end else begin : g_std
                assign oe_o[i]  = dir_i[i];
                assign out_o[i] = dat_i[i];
                assign pull_on  = pe_i[i] & ~dir_i[i];
            end

            assign pu_o[i] = pull_on & ~want_down;
            assign pd_o[i] = pull_on &  want_down;
        end
    endgenerate

endmodule

// File: rtl/gpio_port.sv
module gpio_port
    import gpio_pkg::*;
#(
    parameter int unsigned W              = 8,
    parameter int unsigned SYNC_STAGES    = 2,
    parameter int unsigned OUT_ONLY_BIT   = 4,
    parameter int unsigned OPEN_DRAIN_BIT = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] bus_addr,
    input  logic             bus_we,
    input  logic [W-1:0]     bus_wdata,
    output logic [W-1:0]     bus_rdata,
    input  logic [W-1:0]     pin_in,
    input  logic [W-1:0]     irq_en,
    input  logic [W-1:0]     edge_rise,
    output logic [W-1:0]     pad_oe,
    output logic [W-1:0]     pad_out,
    output logic [W-1:0]     pad_pu,
    output logic [W-1:0]     pad_pd
);

    logic [W-1:0] pin_sync;
    logic [W-1:0] dat_q, dir_q, pe_q;

    gpio_sync #(.W(W), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (pin_in),
        .q_o   (pin_sync)
    );

    gpio_regfile #(.W(W), .OUT_ONLY_BIT(OUT_ONLY_BIT)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .addr_i     (bus_addr),
        .we_i       (bus_we),
        .wdata_i    (bus_wdata),
        .pin_sync_i (pin_sync),
        .dat_o      (dat_q),
        .dir_o      (dir_q),
        .pe_o       (pe_q),
        .rdata_o    (bus_rdata)
    );

    gpio_pad_ctrl #(
        .W              (W),
        .OUT_ONLY_BIT   (OUT_ONLY_BIT),
        .OPEN_DRAIN_BIT (OPEN_DRAIN_BIT)
    ) u_pads (
        .dat_i    (dat_q),
        .dir_i    (dir_q),
        .pe_i     (pe_q),
        .irq_en_i (irq_en),
        .rise_i   (edge_rise),
        .oe_o     (pad_oe),
        .out_o    (pad_out),
        .pu_o     (pad_pu),
        .pd_o     (pad_pd)
    );

endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk #(
    parameter int unsigned W              = 8,
    parameter int unsigned OUT_ONLY_BIT   = 4,
    parameter int unsigned OPEN_DRAIN_BIT = 5
) (
    input logic         clk,
    input logic         rst_n,
    input logic [1:0]   bus_addr,
    input logic         bus_we,
    input logic [W-1:0] bus_rdata,
    input logic [W-1:0] pin_in,
    input logic [W-1:0] pad_oe,
    input logic [W-1:0] pad_out,
    input logic [W-1:0] pad_pu,
    input logic [W-1:0] pad_pd,
    input logic [W-1:0] dat_q,
    input logic [W-1:0] dir_q,
    input logic [W-1:0] pe_q
);

    localparam logic [W-1:0] ONLY_MASK = W'(1) << OUT_ONLY_BIT;
    localparam logic [W-1:0] OD_MASK   = W'(1) << OPEN_DRAIN_BIT;
    localparam logic [W-1:0] STD_MASK  = ~(ONLY_MASK | OD_MASK);

    logic [1:0] live_cnt;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              live_cnt <= '0;
        else if (live_cnt != 2'd2) live_cnt <= live_cnt + 2'd1;
    end

    AST_PULL_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_pu & pad_pd) == '0); // R7

    AST_OUT_ONLY_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
        pad_oe[OUT_ONLY_BIT] && !pad_pu[OUT_ONLY_BIT] && !pad_pd[OUT_ONLY_BIT]); // R8

    AST_OPEN_DRAIN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !pad_out[OPEN_DRAIN_BIT]); // R9

    AST_NO_PULL_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_oe & (pad_pu | pad_pd) & STD_MASK) == '0); // R6

    AST_SPARE_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == 2'd3) |=> ($stable(dat_q) && $stable(dir_q) && $stable(pe_q))); // R2

    AST_INPUT_READ_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
        (live_cnt == 2'd2 && bus_addr == 2'd0)
            |-> (((bus_rdata ^ $past(pin_in, 2)) & ~dir_q & ~ONLY_MASK) == '0)); // R3

endmodule

bind gpio_port gpio_port_chk #(
    .W              (W),
    .OUT_ONLY_BIT   (OUT_ONLY_BIT),
    .OPEN_DRAIN_BIT (OPEN_DRAIN_BIT)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_rdata (bus_rdata),
    .pin_in    (pin_in),
    .pad_oe    (pad_oe),
    .pad_out   (pad_out),
    .pad_pu    (pad_pu),
    .pad_pd    (pad_pd),
    .dat_q     (dat_q),
    .dir_q     (dir_q),
    .pe_q      (pe_q)
);

// File: tb/gpio_port_tb_top.sv
`timescale 1ns/100ps
module gpio_port_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] bus_addr = '0;
    logic       bus_we = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [7:0] pin_in = '0;
    logic [7:0] irq_en = '0;
    logic [7:0] edge_rise = '0;
    logic [7:0] pad_oe, pad_out, pad_pu, pad_pd;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [7:0] m_dat = '0, m_dir = '0, m_pe = '0;

    always #2 clk = ~clk;

    gpio_port dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .irq_en(irq_en), .edge_rise(edge_rise), .pad_oe(pad_oe),
        .pad_out(pad_out), .pad_pu(pad_pu), .pad_pd(pad_pd)
    );

    function automatic logic [7:0] e_oe();
        logic [7:0] v;
        for (int i = 0; i < 8; i++)
            v[i] = (i == 4) ? 1'b1 : (i == 5) ? (m_dir[i] & ~m_dat[i]) : m_dir[i];
        return v;
    endfunction

    function automatic logic [7:0] e_out();
        logic [7:0] v = m_dat;
        v[5] = 1'b0;
        return v;
    endfunction

    function automatic logic [7:0] e_pull();
        logic [7:0] v;
        for (int i = 0; i < 8; i++)
            v[i] = (i == 4) ? 1'b0 : (i == 5) ? m_pe[i] : (m_pe[i] & ~m_dir[i]);
        return v;
    endfunction

    function automatic logic [7:0] e_read(input logic [1:0] a, input logic [7:0] pins);
        logic [7:0] v;
        case (a)
            2'd0: for (int i = 0; i < 8; i++)
                      v[i] = (i == 4 || m_dir[i]) ? m_dat[i] : pins[i];
            2'd1: v = m_dir;
            2'd2: v = m_pe;
            default: v = '0;
        endcase
        return v;
    endfunction

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_we = 1'b1; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
        case (a)
            2'd0: m_dat = d;
            2'd1: m_dir = d;
            2'd2: m_pe  = d;
            default: ;
        endcase
    endtask

    task automatic rd_chk(input string tag, input logic [1:0] a, input logic [7:0] pins);
        bus_addr = a;
        #0.5;
        chk(tag, bus_rdata, e_read(a, pins));
    endtask

    task automatic pads_chk();
        logic [7:0] dn = irq_en & edge_rise;
        chk("R4 oe", pad_oe, e_oe());
        chk("R4 out", pad_out, e_out());
        chk("R5 pu", pad_pu, e_pull() & ~dn);
        chk("R7 pd", pad_pd, e_pull() & dn);
    endtask

    initial begin
        void'($urandom(32'h5EED_1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 oe", pad_oe, 8'h10);
        chk("R1 out", pad_out, 8'h00);
        chk("R1 pulls", pad_pu | pad_pd, 8'h00);
        for (int a = 1; a < 4; a++) rd_chk("R1 read", 2'(a), 8'h00);

        // R2 map and spare offset
        wr(2'd0, 8'hA5); wr(2'd1, 8'h3C); wr(2'd2, 8'hC3);
        rd_chk("R2 dir", 2'd1, 8'h00);
        rd_chk("R2 pe", 2'd2, 8'h00);
        wr(2'd3, 8'hFF);
        rd_chk("R2 spare", 2'd3, 8'h00);
        rd_chk("R2 dir kept", 2'd1, 8'h00);
        rd_chk("R2 pe kept", 2'd2, 8'h00);
        chk("R2 dat kept", pad_out, e_out());

        // R3 synchronizer latency on input pins
        wr(2'd1, 8'h00); wr(2'd0, 8'h00);
        @(negedge clk); pin_in = 8'h00; repeat (3) @(negedge clk);
        pin_in = 8'hEF;
        @(negedge clk);
        rd_chk("R3 one edge", 2'd0, 8'h00);
        @(negedge clk);
        rd_chk("R3 two edges", 2'd0, 8'hEF);

        // R6 / R9 / R8 directed
        wr(2'd2, 8'hFF); wr(2'd1, 8'hFF); wr(2'd0, 8'h00);
        irq_en = 8'h00; edge_rise = 8'h00; #0.5;
        chk("R6 no pull on outputs", pad_pu & ~8'h20, 8'h00);
        chk("R9 od pull kept", pad_pu & 8'h20, 8'h20);
        chk("R9 od drives low", pad_oe & 8'h20, 8'h20);
        wr(2'd0, 8'hFF); #0.5;
        chk("R9 od released", pad_oe & 8'h20, 8'h00);
        chk("R9 never high", pad_out & 8'h20, 8'h00);
        wr(2'd1, 8'h00); wr(2'd2, 8'h00); wr(2'd0, 8'h10);
        pin_in = 8'h00; repeat (3) @(negedge clk);
        chk("R8 oe", pad_oe & 8'h10, 8'h10);
        chk("R8 out", pad_out & 8'h10, 8'h10);
        rd_chk("R8 read latch", 2'd0, 8'h00);
        wr(2'd1, 8'h10); wr(2'd2, 8'h10);
        rd_chk("R8 dir readback", 2'd1, 8'h00);
        rd_chk("R8 pe readback", 2'd2, 8'h00);
        chk("R8 pulls off", (pad_pu | pad_pd) & 8'h10, 8'h00);

        // R7 polarity directed
        wr(2'd1, 8'h00); wr(2'd2, 8'hFF);
        irq_en = 8'h0F; edge_rise = 8'h33; #0.5;
        chk("R7 pd", pad_pd, 8'h03 | 8'h00);
        chk("R7 pu", pad_pu, 8'hEC);

        // Random phase
        for (int n = 0; n < 400; n++) begin
            logic [7:0] pins;
            @(negedge clk);
            pins = 8'($urandom);
            pin_in = pins;
            irq_en = 8'($urandom);
            edge_rise = 8'($urandom);
            bus_addr = 2'($urandom);
            bus_wdata = 8'($urandom);
            bus_we = 1'b1;
            @(negedge clk);
            bus_we = 1'b0;
            case (bus_addr)
                2'd0: m_dat = bus_wdata;
                2'd1: m_dir = bus_wdata;
                2'd2: m_pe  = bus_wdata;
                default: ;
            endcase
            repeat (2) @(negedge clk);
            #0.5;
            pads_chk();
            rd_chk("R3 data", 2'd0, pins);
            rd_chk("R2 dir", 2'd1, pins);
            rd_chk("R2 pe", 2'd2, pins);
            rd_chk("R2 spare", 2'd3, pins);
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule